// File: doc/BRIEF.md
# SMI Controller with Idle Countdown Timer

This block raises system-management interrupts and clock-stop requests for a power-management subsystem. Software programs an 8-bit control word and an idle reload value through a small register port. An idle countdown timer is reloaded whenever the platform reports activity and steps down at a selectable tick rate; when it runs out it records a timer SMI event. A second event source, an external SMI strobe, is recorded alongside it. Recorded events stay pending until software clears them with write-one-to-clear. The active-low SMI output is driven only while the gate bit is set and an event is pending.

The block also watches accesses to the power-management control port, presented as a single hit strobe with a write flag. When clock-stop requests are enabled, a read of that port pulls the active-low clock-stop output low. Any write to the port, or software clearing the enable bit, releases it.

Top module: `smi_idle_ctrl`

## Requirements
- R1: After reset the control word, reload value, timer count and status all read 0, and smi_n and stpclk_n are both 1.
- R2: Register addresses are 0 control, 1 reload, 2 status, 3 live timer count (read only). Control bit 0 is the SMI gate, bit 1 the clock-stop enable, bit 2 the clock-scale enable (stored and read back only), bits 4:3 the tick select. Bits 7:5 read as 0 whatever was written.
- R3: Tick select 00 ticks once every MIN_CYC clocks, 01 freezes the timer, 10 ticks every clock, and 11 ticks once every MS_CYC clocks. Any control write restarts the tick phase, so the first tick falls on the P-th clock edge after the write edge, where P is the selected period.
- R4: A reload-register write loads the written value into the timer. An activity strobe loads the stored reload value. Both take priority over a tick. Otherwise each tick lowers a nonzero count by one.
- R5: A tick that takes the count from 1 to 0 sets status bit 0. A count at 0 stays at 0 and raises no further event.
- R6: An ext_smi_evt pulse sets status bit 1, whatever the gate bit holds.
- R7: Writing the status register clears each bit written as 1. A new event in the same cycle wins over the clear.
- R8: smi_n is 0 exactly while the gate bit is 1 and a status bit is set. Setting the gate with an event already pending drives smi_n low in the cycle right after the control write.
- R9: A port read hit (pm_port_hit=1, pm_port_wr=0) while the clock-stop enable is 1 drives stpclk_n low from the next cycle. A read hit while the enable is 0 has no effect.
- R10: Any port write hit clears the clock-stop enable bit and releases stpclk_n, and this wins over a control write in the same cycle. Software writing 0 to the enable bit also releases stpclk_n.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 2 | Register address |
| cfg_wdata | input | 8 | Register write data |
| cfg_rdata | output | 8 | Read data for cfg_addr, combinational |
| pm_port_hit | input | 1 | Access to the power-management control port |
| pm_port_wr | input | 1 | 1 when that access is a write |
| activity | input | 1 | Activity strobe, reloads the idle timer |
| ext_smi_evt | input | 1 | External SMI event strobe |
| smi_n | output | 1 | Active-low SMI request |
| stpclk_n | output | 1 | Active-low clock-stop request |

## Verification
A frozen-tick run holds a programmed count for many clocks, which separates the freeze selection from a slow period. A millisecond-mode run checks that the count changes on the exact edge the period predicts, which catches an off-by-one in the prescaler. Events are raised with the gate closed and the gate is opened later, which separates event recording from output masking. Port reads with and without the enable, port writes, and a port write that collides with a control write tell the set rule, the release rule and their priority apart. Long random mixes of register writes, port hits, activity and events then compare every register and both pins against a bench model on each clock.

// File: rtl/smi_pkg.sv
package smi_pkg;

  typedef enum logic [1:0] {
    TK_MINUTE = 2'b00,
    TK_FROZEN = 2'b01,
    TK_CLOCK  = 2'b10,
    TK_MSEC   = 2'b11
  } tick_sel_e;

  localparam logic [1:0] A_CTRL   = 2'd0;
  localparam logic [1:0] A_RELOAD = 2'd1;
  localparam logic [1:0] A_STATUS = 2'd2;
  localparam logic [1:0] A_COUNT  = 2'd3;

  // control word bit positions
  localparam int B_GATE  = 0;
  localparam int B_STPEN = 1;
  localparam int B_SCALE = 2;
  localparam int B_SEL_L = 3;

  // number of clocks per tick; 0 means the tick never fires
  function automatic logic [31:0] tick_period(tick_sel_e sel,
                                              logic [31:0] min_cyc,
                                              logic [31:0] ms_cyc);
    case (sel)
      TK_MINUTE: return min_cyc;
      TK_CLOCK:  return 32'd1;
      TK_MSEC:   return ms_cyc;
      default:   return 32'd0;
    endcase
  endfunction

  // next idle count given load and tick conditions
  function automatic logic [7:0] idle_next(logic [7:0] cur, logic load,
                                           logic [7:0] load_val, logic tick);
    if (load)                     return load_val;
    else if (tick && cur != 8'd0) return cur - 8'd1;
    else                          return cur;
  endfunction

endpackage

// File: rtl/smi_tick_gen.sv
module smi_tick_gen #(
  parameter int unsigned MIN_CYC = 1_980_000_000,
  parameter int unsigned MS_CYC  = 33_000
) (
  input  logic                clk,
  input  logic                rst_n,
  input  smi_pkg::tick_sel_e  sel,
  input  logic                restart,
  output logic                tick
);
  localparam int unsigned MAXP  = (MIN_CYC > MS_CYC) ? MIN_CYC : MS_CYC;
  localparam int          PRE_W = $clog2(MAXP) + 1;

  logic [PRE_W-1:0] pre_q;
  logic [PRE_W-1:0] per_w;
  logic             frozen;

  assign per_w  = PRE_W'(smi_pkg::tick_period(sel, 32'(MIN_CYC), 32'(MS_CYC)));
  assign frozen = (per_w == '0);
  assign tick   = !frozen && (pre_q == per_w - 1'b1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       pre_q <= '0;
    else if (restart) pre_q <= '0;
    else if (frozen)  pre_q <= pre_q;
    else if (tick)    pre_q <= '0;
    else              pre_q <= pre_q + 1'b1;
  end

  AST_FROZEN_NO_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    (sel == smi_pkg::TK_FROZEN) |-> !tick); // R3
  AST_CLOCK_EVERY: assert property (@(posedge clk) disable iff (!rst_n)
    (sel == smi_pkg::TK_CLOCK) && !restart |=> (sel != smi_pkg::TK_CLOCK) || tick); // R3

endmodule

// File: rtl/smi_idle_timer.sv
module smi_idle_timer #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic [CNT_W-1:0] count,
  output logic             expire
);
  logic [CNT_W-1:0] cnt_q;

  assign count  = cnt_q;
  assign expire = tick && !load && (cnt_q == CNT_W'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                     cnt_q <= '0;
    else if (load)                  cnt_q <= load_val;
    else if (tick && cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
  end

  AST_TMR_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> count == $past(load_val)); // R4
  AST_TMR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    tick && !load && (count != '0) |=> count == $past(count) - 1'b1); // R4
  AST_TMR_EXPIRE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    expire |=> count == '0); // R5
  AST_TMR_ZERO_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (count == '0) && !load |=> count == '0); // R5

endmodule

// File: rtl/smi_evt_ctrl.sv
module smi_evt_ctrl #(
  parameter int N_SRC = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_SRC-1:0] ev_set,
  input  logic             clr_we,
  input  logic [N_SRC-1:0] clr_mask,
  input  logic             gate,
  output logic [N_SRC-1:0] pend,
  output logic             smi_n
);
  logic [N_SRC-1:0] pend_q;

  for (genvar i = 0; i < N_SRC; i++) begin : g_src
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pend_q[i] <= 1'b0;
      else        pend_q[i] <= ev_set[i] | (pend_q[i] & ~(clr_we & clr_mask[i]));
    end

    AST_EVT_RECORD: assert property (@(posedge clk) disable iff (!rst_n)
      ev_set[i] |=> pend_q[i]); // R6
    AST_EVT_W1C: assert property (@(posedge clk) disable iff (!rst_n)
      clr_we && clr_mask[i] && !ev_set[i] |=> !pend_q[i]); // R7
    AST_EVT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      pend_q[i] && !(clr_we && clr_mask[i]) |=> pend_q[i]); // R7
  end

  assign pend  = pend_q;
  assign smi_n = ~(gate & (|pend_q));

endmodule

// File: rtl/smi_stp_ctrl.sv
module smi_stp_ctrl (
  input  logic clk,
  input  logic rst_n,
  input  logic port_hit,
  input  logic port_wr,
  input  logic en_we,
  input  logic en_val,
  output logic en,
  output logic stp_act
);
  logic en_q, stp_q;
  logic en_d, stp_d;
  logic port_rd_hit, port_wr_hit;

  assign port_rd_hit = port_hit && !port_wr;
  assign port_wr_hit = port_hit && port_wr;

  always_comb begin
    if (port_wr_hit) en_d = 1'b0;
    else if (en_we)  en_d = en_val;
    else             en_d = en_q;
    stp_d = en_d && (stp_q || (port_rd_hit && en_q));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q  <= 1'b0;
      stp_q <= 1'b0;
    end else begin
      en_q  <= en_d;
      stp_q <= stp_d;
    end
  end

  assign en      = en_q;
  assign stp_act = stp_q;

  AST_STP_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
    stp_q |-> en_q); // R10
  AST_PORT_WR_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
    port_wr_hit |=> !en_q && !stp_q); // R10
  AST_RD_ASSERTS: assert property (@(posedge clk) disable iff (!rst_n)
    port_rd_hit && en_q && !en_we |=> stp_q); // R9
  AST_RD_NO_EN: assert property (@(posedge clk) disable iff (!rst_n)
    port_rd_hit && !en_q && !stp_q |=> !stp_q); // R9

endmodule

// File: rtl/smi_idle_ctrl.sv
module smi_idle_ctrl #(
  parameter int          DATA_W  = 8,
  parameter int unsigned MIN_CYC = 1_980_000_000,
  parameter int unsigned MS_CYC  = 33_000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [1:0]        cfg_addr,
  input  logic [DATA_W-1:0] cfg_wdata,
  output logic [DATA_W-1:0] cfg_rdata,
  input  logic              pm_port_hit,
  input  logic              pm_port_wr,
  input  logic              activity,
  input  logic              ext_smi_evt,
  output logic              smi_n,
  output logic              stpclk_n
);
  import smi_pkg::*;

  localparam int CNT_W = DATA_W;
  localparam int N_SRC = 2;

  logic                gate_q, scale_q;
  tick_sel_e           sel_q;
  logic [CNT_W-1:0]    reload_q;

  logic                wr_ctrl, wr_reload, wr_status;
  logic                tick, expire, tmr_load, stp_en, stp_act;
  logic [CNT_W-1:0]    tmr_count, tmr_load_val;
  logic [N_SRC-1:0]    pend, ev_set;

  assign wr_ctrl   = cfg_we && (cfg_addr == A_CTRL);
  assign wr_reload = cfg_we && (cfg_addr == A_RELOAD);
  assign wr_status = cfg_we && (cfg_addr == A_STATUS);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gate_q   <= 1'b0;
      scale_q  <= 1'b0;
      sel_q    <= TK_MINUTE;
      reload_q <= '0;
    end else begin
      if (wr_ctrl) begin
        gate_q  <= cfg_wdata[B_GATE];
        scale_q <= cfg_wdata[B_SCALE];
        sel_q   <= tick_sel_e'(cfg_wdata[B_SEL_L +: 2]);
      end
      if (wr_reload) reload_q <= cfg_wdata;
    end
  end

  smi_tick_gen #(.MIN_CYC(MIN_CYC), .MS_CYC(MS_CYC)) u_tick (
    .clk(clk), .rst_n(rst_n), .sel(sel_q), .restart(wr_ctrl), .tick(tick)
  );

  assign tmr_load     = wr_reload || activity;
  assign tmr_load_val = wr_reload ? cfg_wdata : reload_q;

  smi_idle_timer #(.CNT_W(CNT_W)) u_timer (
    .clk(clk), .rst_n(rst_n), .tick(tick), .load(tmr_load),
    .load_val(tmr_load_val), .count(tmr_count), .expire(expire)
  );

  assign ev_set = {ext_smi_evt, expire};

  smi_evt_ctrl #(.N_SRC(N_SRC)) u_evt (
    .clk(clk), .rst_n(rst_n), .ev_set(ev_set), .clr_we(wr_status),
    .clr_mask(cfg_wdata[N_SRC-1:0]), .gate(gate_q), .pend(pend), .smi_n(smi_n)
  );

  smi_stp_ctrl u_stp (
    .clk(clk), .rst_n(rst_n), .port_hit(pm_port_hit), .port_wr(pm_port_wr),
    .en_we(wr_ctrl), .en_val(cfg_wdata[B_STPEN]), .en(stp_en), .stp_act(stp_act)
  );

  assign stpclk_n = ~stp_act;

  always_comb begin
    cfg_rdata = '0;
    case (cfg_addr)
      A_CTRL: begin
        cfg_rdata[B_GATE]       = gate_q;
        cfg_rdata[B_STPEN]      = stp_en;
        cfg_rdata[B_SCALE]      = scale_q;
        cfg_rdata[B_SEL_L +: 2] = sel_q;
      end
      A_RELOAD: cfg_rdata = reload_q;
      A_STATUS: cfg_rdata[N_SRC-1:0] = pend;
      default:  cfg_rdata = tmr_count;
    endcase
  end

  AST_EXPIRE_RECORDED: assert property (@(posedge clk) disable iff (!rst_n)
    expire |=> pend[0]); // R5
  AST_GATE_OPEN_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
    wr_ctrl && cfg_wdata[B_GATE] && (pend != '0) && !wr_status |=> !smi_n); // R8
  AST_GATE_CLOSED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    wr_ctrl && !cfg_wdata[B_GATE] |=> smi_n); // R8

endmodule

// File: tb/smi_idle_ctrl_bench.sv
module smi_idle_ctrl_bench;
  localparam int MIN_C = 20;
  localparam int MS_C  = 5;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cfg_we = 1'b0;
  logic [1:0] cfg_addr = 2'd0;
  logic [7:0] cfg_wdata = 8'd0;
  logic [7:0] cfg_rdata;
  logic       pm_port_hit = 1'b0, pm_port_wr = 1'b0;
  logic       activity = 1'b0, ext_smi_evt = 1'b0;
  logic       smi_n, stpclk_n;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;

  // bench model state
  bit         m_gate, m_scale, m_en, m_stp;
  bit [1:0]   m_sel;
  bit [7:0]   m_reload, m_cnt;
  bit [1:0]   m_pend;
  int         m_phase;

  always #4 clk = ~clk;

  smi_idle_ctrl #(.DATA_W(8), .MIN_CYC(MIN_C), .MS_CYC(MS_C)) u_smi_idle_ctrl (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .pm_port_hit(pm_port_hit),
    .pm_port_wr(pm_port_wr), .activity(activity), .ext_smi_evt(ext_smi_evt),
    .smi_n(smi_n), .stpclk_n(stpclk_n)
  );

  function automatic int period_of(bit [1:0] s);
    if (s == 2'b01) return 0;
    if (s == 2'b10) return 1;
    if (s == 2'b11) return MS_C;
    return MIN_C;
  endfunction

  function automatic bit [7:0] model_read(bit [1:0] a);
    if (a == 2'd0) return {3'b000, m_sel, m_scale, m_en, m_gate};
    if (a == 2'd1) return m_reload;
    if (a == 2'd2) return {6'd0, m_pend};
    return m_cnt;
  endfunction

  function automatic string tag_of(bit [1:0] a);
    if (a == 2'd0) return "R2";
    if (a == 2'd2) return "R7";
    return "R4";
  endfunction

  task automatic check(bit ok, string tag, int act, int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h t=%0t", tag, act, exp, $time);
    end
  endtask

  task automatic model_compare();
    check(cfg_rdata == model_read(cfg_addr), tag_of(cfg_addr), cfg_rdata, model_read(cfg_addr));
    check(smi_n == !(m_gate && m_pend != 0), "R8", smi_n, !(m_gate && m_pend != 0));
    check(stpclk_n == !m_stp, "R9", stpclk_n, !m_stp);
  endtask

  task automatic model_update();
    int  per;
    bit  tk, ld, exp_ev, wc, wr_rl, ws, en_n;
    bit [7:0] ld_val;
    per    = period_of(m_sel);
    tk     = (per != 0) && (m_phase == per - 1);
    wc     = cfg_we && cfg_addr == 2'd0;
    wr_rl  = cfg_we && cfg_addr == 2'd1;
    ws     = cfg_we && cfg_addr == 2'd2;
    ld     = wr_rl || activity;
    ld_val = wr_rl ? cfg_wdata : m_reload;
    exp_ev = tk && !ld && m_cnt == 8'd1;
    if (ld) m_cnt = ld_val;
    else if (tk && m_cnt != 0) m_cnt = m_cnt - 8'd1;
    if (wc) m_phase = 0;
    else if (per == 0) m_phase = m_phase;
    else if (tk) m_phase = 0;
    else m_phase = m_phase + 1;
    for (int b = 0; b < 2; b++) begin
      bit s;
      s = (b == 0) ? exp_ev : ext_smi_evt;
      m_pend[b] = s | (m_pend[b] & !(ws && cfg_wdata[b]));
    end
    if (pm_port_hit && pm_port_wr) en_n = 1'b0;
    else if (wc) en_n = cfg_wdata[1];
    else en_n = m_en;
    m_stp = en_n && (m_stp || (pm_port_hit && !pm_port_wr && m_en));
    m_en  = en_n;
    if (wc) begin
      m_gate  = cfg_wdata[0];
      m_scale = cfg_wdata[2];
      m_sel   = cfg_wdata[4:3];
    end
    if (wr_rl) m_reload = cfg_wdata;
  endtask

  task automatic step(bit we, bit [1:0] a, bit [7:0] d, bit hit, bit wr, bit act, bit ev);
    @(negedge clk);
    cfg_we = we; cfg_addr = a; cfg_wdata = d;
    pm_port_hit = hit; pm_port_wr = wr; activity = act; ext_smi_evt = ev;
    #1;
    model_compare();
    @(posedge clk);
    model_update();
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) step(0, 2'd3, 8'd0, 0, 0, 0, 0);
  endtask

  task automatic wreg(bit [1:0] a, bit [7:0] d);
    step(1, a, d, 0, 0, 0, 0);
  endtask

  // literal expectation on a register and both pins, then one idle cycle
  task automatic probe(bit [1:0] a, bit [7:0] exp_d, bit exp_smi, bit exp_stp, string tag);
    @(negedge clk);
    cfg_we = 0; cfg_addr = a; cfg_wdata = 0;
    pm_port_hit = 0; pm_port_wr = 0; activity = 0; ext_smi_evt = 0;
    #1;
    check(cfg_rdata == exp_d, tag, cfg_rdata, exp_d);
    check(smi_n == exp_smi, tag, smi_n, exp_smi);
    check(stpclk_n == exp_stp, tag, stpclk_n, exp_stp);
    model_compare();
    @(posedge clk);
    model_update();
  endtask

  task automatic report();
    if (!done) begin
      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_tests++;
    n_fail++;
    $display("FAIL watchdog actual=running expected=finished");
    report();
  end

  initial begin
    m_gate = 0; m_scale = 0; m_en = 0; m_stp = 0; m_sel = 0;
    m_reload = 0; m_cnt = 0; m_pend = 0; m_phase = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    probe(2'd0, 8'h00, 1, 1, "R1");
    probe(2'd1, 8'h00, 1, 1, "R1");
    probe(2'd2, 8'h00, 1, 1, "R1");
    probe(2'd3, 8'h00, 1, 1, "R1");

    // R2 reserved bits read zero, scale bit stored
    wreg(2'd0, 8'hE4);
    probe(2'd0, 8'h04, 1, 1, "R2");

    // R3 frozen: count held
    wreg(2'd1, 8'h30);
    wreg(2'd0, 8'h08);
    idle(25);
    probe(2'd3, 8'h30, 1, 1, "R3");

    // R3 millisecond period: first decrement on the 5th edge after the write
    wreg(2'd0, 8'h18);
    idle(4);
    probe(2'd3, 8'h30, 1, 1, "R3");
    probe(2'd3, 8'h2F, 1, 1, "R3");

    // R4 activity reloads stored value
    idle(10);
    step(0, 2'd3, 8'd0, 0, 0, 1, 0);
    probe(2'd3, 8'h30, 1, 1, "R4");

    // R5 expiry in clock mode
    wreg(2'd0, 8'h10);
    wreg(2'd1, 8'h02);
    probe(2'd3, 8'h02, 1, 1, "R5");
    probe(2'd3, 8'h01, 1, 1, "R5");
    probe(2'd2, 8'h01, 1, 1, "R5");
    idle(3);
    probe(2'd3, 8'h00, 1, 1, "R5");

    // R8 gate opened with pending event
    wreg(2'd0, 8'h11);
    probe(2'd2, 8'h01, 0, 1, "R8");

    // R7 write-one-to-clear
    wreg(2'd2, 8'h01);
    probe(2'd2, 8'h00, 1, 1, "R7");

    // R6 external event recorded, then masked by closed gate
    step(0, 2'd3, 8'd0, 0, 0, 0, 1);
    probe(2'd2, 8'h02, 0, 1, "R6");
    wreg(2'd0, 8'h10);
    probe(2'd2, 8'h02, 1, 1, "R8");
    // R7 set wins over same-cycle clear
    step(1, 2'd2, 8'h02, 0, 0, 0, 1);
    probe(2'd2, 8'h02, 1, 1, "R7");
    wreg(2'd2, 8'h03);

    // R9 read without enable has no effect
    step(0, 2'd3, 8'd0, 1, 0, 0, 0);
    probe(2'd0, 8'h10, 1, 1, "R9");
    wreg(2'd0, 8'h12);
    step(0, 2'd3, 8'd0, 1, 0, 0, 0);
    probe(2'd0, 8'h12, 1, 0, "R9");

    // R10 port write releases
    step(0, 2'd3, 8'd0, 1, 1, 0, 0);
    probe(2'd0, 8'h10, 1, 1, "R10");
    wreg(2'd0, 8'h12);
    step(0, 2'd3, 8'd0, 1, 0, 0, 0);
    wreg(2'd0, 8'h10);
    probe(2'd0, 8'h10, 1, 1, "R10");
    // R10 port write beats control write
    step(1, 2'd0, 8'h12, 1, 1, 0, 0);
    probe(2'd0, 8'h10, 1, 1, "R10");

    // random mix against the model
    void'($urandom(32'h5EED_0B2));
    for (int i = 0; i < 4000; i++) begin
      bit we, hit, wr, act, ev;
      bit [1:0] a;
      bit [7:0] d;
      we  = ($urandom % 6) == 0;
      a   = 2'($urandom);
      d   = 8'($urandom);
      if (a == 2'd1) d = d & 8'h1F;
      hit = ($urandom % 10) == 0;
      wr  = 1'($urandom);
      act = ($urandom % 40) == 0;
      ev  = ($urandom % 50) == 0;
      step(we, a, d, hit, wr, act, ev);
    end
    report();
  end

endmodule